// File: doc/BRIEF.md
# Local Lock Assist Sequencer

This block carries out one privileged lock instruction per request: it either obtains or releases the local lock of an address space. It does this with a fixed series of 32-bit reads and writes on a single word-wide memory port. The caller supplies the following:
- the operation (obtain or release);
- two operand addresses;
- the current instruction address;
- a privileged-state flag;
- the address-wrap mask in force.

The block reads three words from memory:
- the address-space block pointer, taken from operand 1;
- the locks-held word, taken from operand 2;
- this processor's logical CPU address, from the word just below operand 2.

It then reads the lock word, and for a release also the suspend-queue word. The lock word sits at offset 0x080 from the block pointer and the suspend-queue word at 0x084.

If the lock test passes, the block updates memory and reports success by writing zero to register 13. If the test fails, it does not just flag an error. It reads a table pointer from the word after operand 2 and fetches a new instruction address from a fixed negative offset below that pointer. It then returns register 12 (the link) and register 13 (the new address), and signals a taken branch.

A bus-lock output stays high for the whole sequence, so that no other requester can slip accesses in between. A privilege violation or a misaligned operand ends the request before any memory access. An error response from memory aborts the sequence. Every result comes with a one-cycle done pulse.

Top module: `lcl_lock_seq`

## Requirements
- R1: With `req_priv` low, an accepted request raises `exc_priv` at done. It makes no memory access, writes no register and takes no branch. This check comes before the alignment check.
- R2: With `req_priv` high and either operand address having bit 0 or bit 1 set, the request raises `exc_spec` at done with no memory access.
- R3: The sequence reads the following addresses, in order:
  - operand 1;
  - operand 2;
  - operand 2 minus 4;
  - block pointer plus 0x080;
  - for a release only, block pointer plus 0x084.

  Every address placed on `mem_addr` is ANDed with the wrap mask latched at acceptance.
- R4: An obtain (`req_release`=0) succeeds when the lock word is zero and bit 0 of the locks-held word is 0. It then makes three writes, in order:
  1. the locks-held word, unchanged, to operand 2;
  2. the CPU address, to the lock word;
  3. the locks-held word with bit 0 set, to operand 2.

  It ends with register 13 written to zero, register 12 not written and no branch.
- R5: A release (`req_release`=1) succeeds when all four of these hold:
  - the lock word equals the CPU address;
  - bit 0 of the locks-held word is 1;
  - bit 1 of the locks-held word is 0;
  - the suspend-queue word is zero.

  It then makes three writes, in order:
  1. the locks-held word, unchanged, to operand 2;
  2. zero, to the lock word;
  3. the locks-held word with bit 0 cleared, to operand 2.

  It ends with register 13 written to zero and no branch.
- R6: When the lock test fails, the block works out a branch in this order:
  1. It reads the table pointer at operand 2 plus 4.
  2. It adds -16 to the pointer for an obtain or -12 for a release, and masks the result.
  3. It reads the new instruction address from there.

  At done, register 12 gets the request's instruction address, and register 13 and `br_target` get the new address, with `br_taken` high. No write is made.
- R7: `bus_lock` is high during every memory access of a sequence. It is low while idle and in the done cycle.
- R8: A response with `mem_err` high ends the sequence. The block then raises `exc_access` at done, makes no further access, writes no register and takes no branch. Memory is left as the writes before the error set it.
- R9: `done` is high for exactly one cycle, the cycle after the final memory response (or after acceptance for R1/R2). `idle` is high only when no request is in progress, and `req_valid` is ignored while `idle` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start request (taken only when idle) |
| req_release | input | 1 | 0 = obtain, 1 = release |
| req_op1_addr | input | AW | Operand 1 address (holds block pointer) |
| req_op2_addr | input | AW | Operand 2 address (locks-held word) |
| req_ia | input | AW | Current instruction address |
| req_priv | input | 1 | Processor is in privileged state |
| wrap_mask | input | AW | Address-wrap mask |
| idle | output | 1 | Ready for a request |
| mem_req | output | 1 | Memory access request (one-cycle strobe) |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Access address |
| mem_wdata | output | AW | Write data |
| mem_rsp | input | 1 | Response for the outstanding access |
| mem_rdata | input | AW | Read data with the response |
| mem_err | input | 1 | Access error with the response |
| bus_lock | output | 1 | Exclusive memory ownership |
| done | output | 1 | Result valid pulse |
| gr12_we | output | 1 | Register 12 write enable |
| gr12_val | output | AW | Register 12 value (link) |
| gr13_we | output | 1 | Register 13 write enable |
| gr13_val | output | AW | Register 13 value |
| br_taken | output | 1 | Branch to br_target |
| br_target | output | AW | Branch target address |
| exc_priv | output | 1 | Privileged-operation exception |
| exc_spec | output | 1 | Specification exception |
| exc_access | output | 1 | Access exception |

## Verification
The unit issues each access one cycle after the previous response, and memory answers one cycle after the strobe. A successful obtain takes 7 accesses, a successful release 8, and a failure 6 or 7. The result lands in the cycle after the last response, or in the cycle after acceptance for an exception.

The bench does not count these cycles ahead of time. It samples `done` at every falling edge, reads all results in the first cycle where it is high, and confirms that `done` is low again one cycle later. Access order and addresses come from a log that the memory model records, so that the expected write order and wrapped addresses are compared per access rather than per cycle.

// File: rtl/lcl_lock_seq.sv
module lcl_lock_seq #(
  parameter int              AW       = 32,
  parameter logic [AW-1:0]   LOCK_OFS = AW'('h80),
  parameter logic [AW-1:0]   SUSP_OFS = AW'('h84),
  parameter int              OBT_BIAS = -16,
  parameter int              REL_BIAS = -12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_release,
  input  logic [AW-1:0] req_op1_addr,
  input  logic [AW-1:0] req_op2_addr,
  input  logic [AW-1:0] req_ia,
  input  logic          req_priv,
  input  logic [AW-1:0] wrap_mask,
  output logic          idle,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic          mem_rsp,
  input  logic [AW-1:0] mem_rdata,
  input  logic          mem_err,
  output logic          bus_lock,
  output logic          done,
  output logic          gr12_we,
  output logic [AW-1:0] gr12_val,
  output logic          gr13_we,
  output logic [AW-1:0] gr13_val,
  output logic          br_taken,
  output logic [AW-1:0] br_target,
  output logic          exc_priv,
  output logic          exc_spec,
  output logic          exc_access
);

  localparam logic [AW-1:0] WORD    = AW'(4);
  localparam logic [AW-1:0] OBT_ADD = AW'(OBT_BIAS);
  localparam logic [AW-1:0] REL_ADD = AW'(REL_BIAS);

  typedef enum logic [3:0] {
    ST_IDLE, ST_ASCB, ST_HELD, ST_CPU, ST_LOCK, ST_SUSP,
    ST_WHELD0, ST_WLOCK, ST_WHELD1, ST_TBL, ST_NIA, ST_FIN
  } step_t;

  step_t         st;
  logic          pend, is_rel;
  logic [AW-1:0] op1, op2, ia, mask;
  logic [AW-1:0] ascb, held, cpu, lockv, tbl;
  logic          r12_we, r13_we, r_br, r_ep, r_es, r_ea;
  logic [AW-1:0] r13;
  logic [AW-1:0] raw_addr;

  wire access   = (st != ST_IDLE) && (st != ST_FIN);
  wire got      = pend && mem_rsp;
  wire misalign = (|req_op1_addr[1:0]) || (|req_op2_addr[1:0]);
  wire obt_ok   = (mem_rdata == '0) && !held[0];
  wire rel_ok   = (lockv == cpu) && (held[1:0] == 2'b01) && (mem_rdata == '0);

  assign idle     = (st == ST_IDLE);
  assign done     = (st == ST_FIN);
  assign bus_lock = access;
  assign mem_req  = access && !pend;
  assign mem_we   = (st == ST_WHELD0) || (st == ST_WLOCK) || (st == ST_WHELD1);
  assign mem_addr = raw_addr & mask;

  always_comb begin
    raw_addr = op2;
    case (st)
      ST_ASCB:             raw_addr = op1;
      ST_CPU:              raw_addr = op2 - WORD;
      ST_LOCK, ST_WLOCK:   raw_addr = ascb + LOCK_OFS;
      ST_SUSP:             raw_addr = ascb + SUSP_OFS;
      ST_TBL:              raw_addr = op2 + WORD;
      ST_NIA:              raw_addr = (tbl + (is_rel ? REL_ADD : OBT_ADD)) & mask;
      default:             raw_addr = op2;
    endcase
  end

  always_comb begin
    mem_wdata = held;
    if (st == ST_WLOCK)  mem_wdata = is_rel ? '0 : cpu;
    if (st == ST_WHELD1) mem_wdata = is_rel ? (held & ~AW'(1)) : (held | AW'(1));
  end

  assign gr12_we    = done && r12_we;
  assign gr12_val   = ia;
  assign gr13_we    = done && r13_we;
  assign gr13_val   = r13;
  assign br_taken   = done && r_br;
  assign br_target  = r13;
  assign exc_priv   = done && r_ep;
  assign exc_spec   = done && r_es;
  assign exc_access = done && r_ea;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; pend <= 1'b0; is_rel <= 1'b0;
      op1 <= '0; op2 <= '0; ia <= '0; mask <= '0;
      ascb <= '0; held <= '0; cpu <= '0; lockv <= '0; tbl <= '0;
      r12_we <= 1'b0; r13_we <= 1'b0; r_br <= 1'b0;
      r_ep <= 1'b0; r_es <= 1'b0; r_ea <= 1'b0; r13 <= '0;
    end else begin
      if (mem_req) pend <= 1'b1;
      if (got)     pend <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          is_rel <= req_release; op1 <= req_op1_addr; op2 <= req_op2_addr;
          ia <= req_ia; mask <= wrap_mask;
          r12_we <= 1'b0; r13_we <= 1'b0; r_br <= 1'b0;
          r_ep <= 1'b0; r_es <= 1'b0; r_ea <= 1'b0; r13 <= '0;
          if (!req_priv)     begin r_ep <= 1'b1; st <= ST_FIN; end
          else if (misalign) begin r_es <= 1'b1; st <= ST_FIN; end
          else               st <= ST_ASCB;
        end
        ST_FIN: st <= ST_IDLE;
        default: if (got) begin
          if (mem_err) begin
            r_ea <= 1'b1; st <= ST_FIN;
          end else begin
            case (st)
              ST_ASCB:   begin ascb <= mem_rdata; st <= ST_HELD; end
              ST_HELD:   begin held <= mem_rdata; st <= ST_CPU;  end
              ST_CPU:    begin cpu  <= mem_rdata; st <= ST_LOCK; end
              ST_LOCK: begin
                lockv <= mem_rdata;
                if (is_rel)      st <= ST_SUSP;
                else if (obt_ok) st <= ST_WHELD0;
                else             st <= ST_TBL;
              end
              ST_SUSP:   st <= rel_ok ? ST_WHELD0 : ST_TBL;
              ST_WHELD0: st <= ST_WLOCK;
              ST_WLOCK:  st <= ST_WHELD1;
              ST_WHELD1: begin r13_we <= 1'b1; r13 <= '0; st <= ST_FIN; end
              ST_TBL:    begin tbl <= mem_rdata; st <= ST_NIA; end
              ST_NIA: begin
                r12_we <= 1'b1; r13_we <= 1'b1; r13 <= mem_rdata;
                r_br <= 1'b1; st <= ST_FIN;
              end
              default:   st <= ST_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  AST_REQ_UNDER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> bus_lock); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !mem_req && !bus_lock); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_EXC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot0({exc_priv, exc_spec, exc_access})); // R8
  AST_PRIV_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    exc_priv |-> !gr13_we && !br_taken && !gr12_we); // R1
  AST_ERR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_lock && mem_rsp && mem_err) |=> done && exc_access); // R8
  AST_BRANCH_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> gr12_we && gr13_we); // R6

endmodule

// File: tb/lcl_lock_seq_tb_top.sv
module lcl_lock_seq_tb_top;
  localparam int AW = 32;
  localparam logic [31:0] MASK = 32'h0000_03FF;
  localparam logic [31:0] OP1 = 32'h100, OP2 = 32'h204, IA = 32'h0000_1238;
  localparam logic [31:0] CPU = 32'h7, TBLP = 32'h310;
  localparam logic [31:0] NIA_O = 32'h5A00, NIA_R = 32'h5B00;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_release = 0, req_priv = 1;
  logic [31:0] req_op1_addr = OP1, req_op2_addr = OP2, req_ia = IA, wrap_mask = MASK;
  logic idle, mem_req, mem_we, bus_lock, done;
  logic [31:0] mem_addr, mem_wdata, gr12_val, gr13_val, br_target;
  logic mem_rsp = 0, mem_err = 0;
  logic [31:0] mem_rdata = 0;
  logic gr12_we, gr13_we, br_taken, exc_priv, exc_spec, exc_access;

  always #10 clk = ~clk;

  lcl_lock_seq #(.AW(AW)) dut_i (.*);

  logic [31:0] mem [256];
  logic [31:0] log_addr [16];
  logic [31:0] log_data [16];
  logic        log_we [16];
  int acc_n = 0, err_at = -1, lock_bad = 0;
  int checks = 0, failures = 0;
  bit finished = 0;

  always @(posedge clk) begin
    mem_rsp <= 1'b0; mem_err <= 1'b0;
    if (mem_req) begin
      if (!bus_lock) lock_bad = lock_bad + 1;
      if (acc_n < 16) begin
        log_addr[acc_n] = mem_addr; log_data[acc_n] = mem_wdata; log_we[acc_n] = mem_we;
      end
      if (acc_n == err_at) mem_err <= 1'b1;
      else if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      else mem_rdata <= mem[mem_addr[9:2]];
      mem_rsp <= 1'b1;
      acc_n = acc_n + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  logic c12we, c13we, cbr, cep, ces, cea, cbl;
  logic [31:0] c12, c13, ctgt;

  task automatic run(input logic rel, input logic [31:0] o1, input logic [31:0] o2,
                     input logic priv, input bit poke);
    int cyc;
    @(negedge clk);
    acc_n = 0;
    req_valid = 1; req_release = rel; req_op1_addr = o1; req_op2_addr = o2; req_priv = priv;
    @(negedge clk);
    req_valid = 0;
    cyc = 0;
    while (!done && cyc < 100) begin
      @(negedge clk); cyc++;
      if (poke && cyc == 2) begin
        chk("R9 idle low while busy", {31'b0, idle}, 32'd0);
        req_valid = 1; req_release = ~rel; req_priv = 0;
      end else if (poke && cyc == 3) begin
        req_valid = 0; req_priv = 1;
      end
    end
    c12we = gr12_we; c13we = gr13_we; cbr = br_taken; ctgt = br_target;
    c12 = gr12_val; c13 = gr13_val; cep = exc_priv; ces = exc_spec; cea = exc_access;
    cbl = bus_lock;
    chk("R7 bus_lock low at done", {31'b0, cbl}, 32'd0);
    @(negedge clk);
    chk("R9 done single pulse", {31'b0, done}, 32'd0);
    chk("R9 idle after done", {31'b0, idle}, 32'd1);
  endtask

  task automatic setup(input logic [31:0] ascb, input logic [31:0] held,
                       input logic [31:0] lockw, input logic [31:0] susp);
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    mem[OP1[9:2]] = ascb;
    mem[OP2[9:2]] = held;
    mem[(OP2 - 4) >> 2] = CPU;
    mem[(OP2 + 4) >> 2] = TBLP;
    mem[(TBLP - 16) >> 2] = NIA_O;
    mem[(TBLP - 12) >> 2] = NIA_R;
    mem[((ascb + 32'h80) & MASK) >> 2] = lockw;
    mem[((ascb + 32'h84) & MASK) >> 2] = susp;
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] lw, ascb, nh, nl;
    bit ok;
    repeat (3) @(negedge clk);
    chk("R9 reset done", {31'b0, done}, 32'd0);
    chk("R9 reset idle", {31'b0, idle}, 32'd1);
    chk("R7 reset bus_lock", {31'b0, bus_lock}, 32'd0);
    rst_n = 1;
    ascb = 32'h040;

    // R1: privilege, checked before alignment
    setup(ascb, 0, 0, 0);
    run(0, OP1, OP2, 0, 0);
    chk("R1 exc_priv", {31'b0, cep}, 1); chk("R1 no access", acc_n, 0);
    chk("R1 no r13", {31'b0, c13we}, 0);
    run(1, OP1 | 2, OP2, 0, 0);
    chk("R1 priv before spec", {30'b0, cep, ces}, 32'd2);

    // R2: alignment
    run(0, OP1 | 2, OP2, 1, 0);
    chk("R2 exc_spec op1", {31'b0, ces}, 1); chk("R2 no access op1", acc_n, 0);
    run(1, OP1, OP2 | 1, 1, 0);
    chk("R2 exc_spec op2", {31'b0, ces}, 1); chk("R2 no access op2", acc_n, 0);

    // R4/R6 obtain sweep
    for (int lk = 0; lk < 2; lk++)
      for (int h = 0; h < 4; h++) begin
        lw = lk ? 32'h9 : 32'h0;
        setup(ascb, h, lw, 0);
        run(0, OP1, OP2, 1, 0);
        ok = (lk == 0) && ((h & 1) == 0);
        chk("R3 read op1", log_addr[0], OP1);
        chk("R3 read op2", log_addr[1], OP2);
        chk("R3 read cpu", log_addr[2], OP2 - 4);
        chk("R3 read lock", log_addr[3], ascb + 32'h80);
        chk("R4 R6 branch", {31'b0, cbr}, {31'b0, !ok});
        chk("R4 R6 r13 value", c13, ok ? 32'h0 : NIA_O);
        chk("R4 r13 written", {31'b0, c13we}, 1);
        chk("R4 R6 r12 we", {31'b0, c12we}, {31'b0, !ok});
        chk("R4 R6 access count", acc_n, ok ? 7 : 6);
        chk("R4 lock word", mem[(ascb + 32'h80) >> 2], ok ? CPU : lw);
        chk("R4 held word", mem[OP2 >> 2], ok ? (h | 1) : h);
        if (ok) begin
          chk("R4 w1 addr", log_addr[4], OP2); chk("R4 w1 data", log_data[4], h);
          chk("R4 w1 we", {31'b0, log_we[4]}, 1);
          chk("R4 w2 addr", log_addr[5], ascb + 32'h80); chk("R4 w2 data", log_data[5], CPU);
          chk("R4 w3 addr", log_addr[6], OP2); chk("R4 w3 data", log_data[6], h | 1);
        end else begin
          chk("R6 tbl addr", log_addr[4], OP2 + 4);
          chk("R6 nia addr obt", log_addr[5], TBLP - 16);
          chk("R6 r12 link", c12, IA); chk("R6 target", ctgt, NIA_O);
        end
      end

    // R5/R6 release sweep
    for (int lk = 0; lk < 2; lk++)
      for (int h = 0; h < 4; h++)
        for (int s = 0; s < 2; s++) begin
          lw = lk ? 32'h5 : CPU;
          setup(ascb, h, lw, s);
          run(1, OP1, OP2, 1, 0);
          ok = (lk == 0) && ((h & 3) == 1) && (s == 0);
          nl = ok ? 32'h0 : lw;
          nh = ok ? (h & ~1) : h;
          chk("R3 read susp", log_addr[4], ascb + 32'h84);
          chk("R5 R6 branch", {31'b0, cbr}, {31'b0, !ok});
          chk("R5 R6 r13 value", c13, ok ? 32'h0 : NIA_R);
          chk("R5 R6 access count", acc_n, ok ? 8 : 7);
          chk("R5 lock word", mem[(ascb + 32'h80) >> 2], nl);
          chk("R5 held word", mem[OP2 >> 2], nh);
          if (ok) begin
            chk("R5 w1 data", log_data[5], h);
            chk("R5 w2 addr", log_addr[6], ascb + 32'h80); chk("R5 w2 data", log_data[6], 0);
            chk("R5 w3 data", log_data[7], h & ~1);
          end else begin
            chk("R6 nia addr rel", log_addr[6], TBLP - 12);
            chk("R6 r12 link rel", c12, IA);
          end
        end

    // R3 wrap of lock address
    setup(32'h3A0, 0, 0, 0);
    run(0, OP1, OP2, 1, 0);
    chk("R3 wrapped lock read", log_addr[3], 32'h020);
    chk("R3 wrapped lock write", log_addr[5], 32'h020);
    chk("R4 wrapped lock stored", mem[32'h020 >> 2], CPU);

    // R8 access error on the lock write
    setup(ascb, 0, 0, 0);
    err_at = 5;
    run(0, OP1, OP2, 1, 0);
    chk("R8 exc_access", {31'b0, cea}, 1);
    chk("R8 stops", acc_n, 6);
    chk("R8 no branch", {30'b0, cbr, c13we}, 0);
    chk("R8 lock untouched", mem[(ascb + 32'h80) >> 2], 0);
    chk("R8 held unchanged", mem[OP2 >> 2], 0);
    err_at = 0;
    run(1, OP1, OP2, 1, 0);
    chk("R8 error on first read", acc_n, 1);
    chk("R8 exc_access first", {31'b0, cea}, 1);
    err_at = -1;

    // R9 request while busy ignored
    setup(ascb, 0, 0, 0);
    run(0, OP1, OP2, 1, 1);
    chk("R9 busy poke no exc", {31'b0, cep}, 0);
    chk("R9 busy poke count", acc_n, 7);
    repeat (4) @(negedge clk);
    chk("R9 no second run", acc_n, 7);

    chk("R7 bus_lock on every access", lock_bad, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule